// File: doc/BRIEF.md
# Multiplexed Serial Transmit Line Scanner

This block is the transmit side of a four-line asynchronous serial multiplexer. Software reaches it through three 16-bit word registers on a simple memory-mapped bus. The registers are a control/status word, a transmit control word and a write-only data port. A single scanner visits the lines in round-robin order. It stops at the first line that is both enabled and idle, and it raises a ready flag that carries that line's number. Software then writes one character to the shared data port. That character always goes to the line the scanner named. Each line has a one-character shift-out stage and no FIFO.

The scanner is a state machine with four states. In `SC_OFF`, scanning is disabled. `SC_OFF -> SC_HUNT` happens when scanning is enabled. In `SC_HUNT`, the scanner tests one line per clock and advances its pointer on a miss. `SC_HUNT -> SC_OFFER` happens when the tested line is eligible. In `SC_OFFER`, the ready flag is high. `SC_OFFER -> SC_GAP` happens on an accepted data write, and the pointer steps to the next line. `SC_OFFER -> SC_HUNT` happens when software releases the offered line, and the pointer also steps. `SC_GAP -> SC_HUNT` happens after one clock. Every state returns to `SC_OFF` when scanning is disabled or a clear is running.

Each shifter has two states. `SH_IDLE -> SH_SEND` happens on a load. `SH_SEND -> SH_IDLE` happens after the stop bit. The clear sequencer also has two states. `CL_RUN -> CL_WIPE` happens on a clear command. `CL_WIPE -> CL_RUN` happens after `CLR_CYCLES` clocks.

Register map. `bus_addr` is a word address:
- Address 0 is the control/status register.
- Address 1 is the transmit control register.
- Address 2 is the transmit data register.
- Address 3 is unused.

Top module: `serial_tx_mux`

## Requirements
- R1: After reset, address 0 reads 0x0000 and address 1 reads 0x8000. Addresses 2 and 3 read 0. All `ser_out` lines are 1, `tx_irq` is 0 and `modem_dtr` is 0.
- R2: Bits [3:0] of address 1 are the per-line transmit enables, with bit n enabling line n. They read back as written.
- R3: Bit 15 of address 0 is the ready flag, and bits [9:8] hold the offered line number. Those bits read 0 while the flag is clear. The flag is set only for a line that is enabled and whose shifter is idle. The scanner tests one line per clock.
- R4: The search runs round-robin from the pointer. After a line is served or released, the pointer moves to the next line. Turning scanning off keeps the pointer where it is. A clear returns the pointer to line 0.
- R5: A write to address 2 while the flag is set loads `bus_wdata[7:0]` into the offered line's shifter. The flag then reads 0 on the following cycle. A write to address 2 while the flag is clear has no effect.
- R6: Clearing the enable bit of the offered line drops the flag. The search then resumes at the next line.
- R7: Bit 1 of address 0 is the scan enable. While it is 0, the flag stays 0.
- R8: `tx_irq` is 1 exactly when the flag is set and bit 2 of address 0 (the interrupt enable) is 1.
- R9: A loaded line sends a frame starting in the cycle after the write edge. The frame is a 0 start bit, then 8 data bits LSB first, then a 1 stop bit. Each bit lasts `BIT_DIV` clocks. An idle line drives 1, and the other lines are undisturbed.
- R10: Writing address 0 with bit 0 set starts a clear. The clear resets the registers, the scanner and every shifter. Bit 0 reads 1 for `CLR_CYCLES` clocks and then clears by itself. Writes are ignored while the clear runs.
- R11: Bit 15 of address 1 is an active-low terminal-ready control for the modem line. `modem_dtr` is 1 when that bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1 |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational on `bus_addr` |
| ser_out | output | 4 | Serial outputs, one per line |
| tx_irq | output | 1 | Transmit interrupt |
| modem_dtr | output | 1 | Terminal-ready output for the modem line |

## Verification
The main sweep tries every non-empty enable mask, from 0x1 to 0xF, starting from a scan pointer that the bench carries over. The line offered for each mask shows whether the round-robin order picks the right line, including wrap-around. A sweep that only ever offered the lowest enabled line would fail here. Each served line sends a data pattern derived from the mask, sampled in the middle of every bit. This separates bit order, bit timing and cross-line disturbance. Directed patterns then cover:
- releasing the offered line while its neighbour is also disabled;
- data writes with no line offered;
- scan toggling;
- a clear that lands in the middle of a frame;
- writes that arrive during a clear.

// File: rtl/stm_pkg.sv
package stm_pkg;

    localparam logic [1:0] ADDR_CTL = 2'd0;
    localparam logic [1:0] ADDR_TXC = 2'd1;
    localparam logic [1:0] ADDR_TXD = 2'd2;

    localparam int CTL_CLR      = 0;
    localparam int CTL_SCAN     = 1;
    localparam int CTL_TIE      = 2;
    localparam int CTL_LINE_LSB = 8;
    localparam int CTL_RDY      = 15;
    localparam int TXC_DTRN     = 15;

    typedef enum logic [1:0] {
        SC_OFF,
        SC_HUNT,
        SC_OFFER,
        SC_GAP
    } scan_state_e;

    typedef enum logic {
        SH_IDLE,
        SH_SEND
    } shift_state_e;

    typedef enum logic {
        CL_RUN,
        CL_WIPE
    } clr_state_e;

endpackage

// File: rtl/stm_regs.sv
module stm_regs
    import stm_pkg::*;
#(
    parameter int NUM_LINES  = 4,
    parameter int DATA_W     = 8,
    parameter int CLR_CYCLES = 8,
    parameter int LINE_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [1:0]           bus_addr,
    input  logic [15:0]          bus_wdata,
    output logic [15:0]          bus_rdata,
    input  logic                 ready,
    input  logic [LINE_W-1:0]    ready_line,
    output logic                 wipe,
    output logic                 scan_en,
    output logic                 irq_en,
    output logic [NUM_LINES-1:0] line_en,
    output logic                 dtr_n,
    output logic                 load,
    output logic [DATA_W-1:0]    load_data
);

    localparam int CNT_W = (CLR_CYCLES > 1) ? $clog2(CLR_CYCLES) : 1;

    clr_state_e       cl_q, cl_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             wr_ctl, wr_txc, wr_txd, clr_req;

    assign wr_ctl  = bus_sel && bus_we && (bus_addr == ADDR_CTL) && !wipe;
    assign wr_txc  = bus_sel && bus_we && (bus_addr == ADDR_TXC) && !wipe;
    assign wr_txd  = bus_sel && bus_we && (bus_addr == ADDR_TXD) && !wipe;
    assign clr_req = wr_ctl && bus_wdata[CTL_CLR];

    // clear sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cl_q  <= CL_RUN;
            cnt_q <= '0;
        end else begin
            cl_q  <= cl_d;
            cnt_q <= cnt_d;
        end
    end

    // clear sequencer: transitions
    always_comb begin
        cl_d  = cl_q;
        cnt_d = cnt_q;
        unique case (cl_q)
            CL_RUN: begin
                if (clr_req) begin
                    cl_d  = CL_WIPE;
                    cnt_d = CNT_W'(CLR_CYCLES - 1);
                end
            end
            CL_WIPE: begin
                if (cnt_q == '0) cl_d = CL_RUN;
                else             cnt_d = cnt_q - 1'b1;
            end
        endcase
    end

    assign wipe = (cl_q == CL_WIPE);

    // software-visible control state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_en <= 1'b0;
            irq_en  <= 1'b0;
            line_en <= '0;
            dtr_n   <= 1'b1;
        end else if (wipe || clr_req) begin
            scan_en <= 1'b0;
            irq_en  <= 1'b0;
            line_en <= '0;
            dtr_n   <= 1'b1;
        end else begin
            if (wr_ctl) begin
                scan_en <= bus_wdata[CTL_SCAN];
                irq_en  <= bus_wdata[CTL_TIE];
            end
            if (wr_txc) begin
                line_en <= bus_wdata[NUM_LINES-1:0];
                dtr_n   <= bus_wdata[TXC_DTRN];
            end
        end
    end

    assign load      = wr_txd && ready;
    assign load_data = bus_wdata[DATA_W-1:0];

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTL: begin
                bus_rdata[CTL_CLR]  = wipe;
                bus_rdata[CTL_SCAN] = scan_en;
                bus_rdata[CTL_TIE]  = irq_en;
                bus_rdata[CTL_RDY]  = ready;
                bus_rdata[CTL_LINE_LSB +: LINE_W] = ready ? ready_line : '0;
            end
            ADDR_TXC: begin
                bus_rdata[NUM_LINES-1:0] = line_en;
                bus_rdata[TXC_DTRN]      = dtr_n;
            end
            default: bus_rdata = '0;
        endcase
    end

    // R10: a running clear ends by itself
    a_r10_wipe_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (wipe && cnt_q == '0) |=> !wipe)
        else $error("clear did not end");

endmodule

// File: rtl/stm_scanner.sv
module stm_scanner
    import stm_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int LINE_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wipe,
    input  logic                 scan_en,
    input  logic [NUM_LINES-1:0] line_en,
    input  logic [NUM_LINES-1:0] line_busy,
    input  logic                 load,
    output logic                 ready,
    output logic [LINE_W-1:0]    line
);

    scan_state_e       st_q, st_d;
    logic [LINE_W-1:0] ptr_q, ptr_d;
    logic              eligible;

    function automatic logic [LINE_W-1:0] step(input logic [LINE_W-1:0] p);
        if (p == LINE_W'(NUM_LINES - 1)) return '0;
        return p + 1'b1;
    endfunction

    assign eligible = line_en[ptr_q] && !line_busy[ptr_q];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SC_OFF;
            ptr_q <= '0;
        end else if (wipe) begin
            st_q  <= SC_OFF;
            ptr_q <= '0;
        end else begin
            st_q  <= st_d;
            ptr_q <= ptr_d;
        end
    end

    // transitions
    always_comb begin
        st_d  = st_q;
        ptr_d = ptr_q;
        unique case (st_q)
            SC_OFF: begin
                if (scan_en) st_d = SC_HUNT;
            end
            SC_HUNT: begin
                if (!scan_en)     st_d  = SC_OFF;
                else if (eligible) st_d = SC_OFFER;
                else              ptr_d = step(ptr_q);
            end
            SC_OFFER: begin
                if (!scan_en) begin
                    st_d = SC_OFF;
                end else if (load) begin
                    st_d  = SC_GAP;
                    ptr_d = step(ptr_q);
                end else if (!line_en[ptr_q]) begin
                    st_d  = SC_HUNT;
                    ptr_d = step(ptr_q);
                end
            end
            SC_GAP: begin
                st_d = scan_en ? SC_HUNT : SC_OFF;
            end
        endcase
    end

    // outputs
    always_comb begin
        ready = (st_q == SC_OFFER);
        line  = ptr_q;
    end

    a_r3_offer_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !line_busy[line])
        else $error("offered a busy line");

    a_r5_gap_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !ready)
        else $error("ready held after a load");

    a_r6_release_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !line_en[line] && !load && !wipe) |=> !ready)
        else $error("released line still offered");

    a_r7_scan_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> !ready)
        else $error("ready while scanning is off");

    a_r10_wipe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> !ready)
        else $error("ready during clear");

endmodule

// File: rtl/stm_shifter.sv
module stm_shifter
    import stm_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int BIT_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    output logic              busy,
    output logic              txd
);

    localparam int FRAME = DATA_W + 2;
    localparam int BC_W  = $clog2(FRAME);
    localparam int DV_W  = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;

    shift_state_e     st_q, st_d;
    logic [FRAME-1:0] sh_q, sh_d;
    logic [BC_W-1:0]  bit_q, bit_d;
    logic [DV_W-1:0]  div_q, div_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SH_IDLE;
            sh_q  <= '1;
            bit_q <= '0;
            div_q <= '0;
        end else if (wipe) begin
            st_q  <= SH_IDLE;
            sh_q  <= '1;
            bit_q <= '0;
            div_q <= '0;
        end else begin
            st_q  <= st_d;
            sh_q  <= sh_d;
            bit_q <= bit_d;
            div_q <= div_d;
        end
    end

    // transitions
    always_comb begin
        st_d  = st_q;
        sh_d  = sh_q;
        bit_d = bit_q;
        div_d = div_q;
        unique case (st_q)
            SH_IDLE: begin
                if (load) begin
                    st_d  = SH_SEND;
                    sh_d  = {1'b1, data, 1'b0};
                    bit_d = '0;
                    div_d = '0;
                end
            end
            SH_SEND: begin
                if (div_q == DV_W'(BIT_DIV - 1)) begin
                    div_d = '0;
                    sh_d  = {1'b1, sh_q[FRAME-1:1]};
                    bit_d = bit_q + 1'b1;
                    if (bit_q == BC_W'(FRAME - 1)) st_d = SH_IDLE;
                end else begin
                    div_d = div_q + 1'b1;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        busy = (st_q == SH_SEND);
        txd  = busy ? sh_q[0] : 1'b1;
    end

    a_r9_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd)
        else $error("frame did not open with a start bit");

    a_r9_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wipe) |=> busy)
        else $error("load did not start a frame");

endmodule

// File: rtl/serial_tx_mux.sv
module serial_tx_mux
    import stm_pkg::*;
#(
    parameter int NUM_LINES  = 4,
    parameter int DATA_W     = 8,
    parameter int BIT_DIV    = 4,
    parameter int CLR_CYCLES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [1:0]           bus_addr,
    input  logic [15:0]          bus_wdata,
    output logic [15:0]          bus_rdata,
    output logic [NUM_LINES-1:0] ser_out,
    output logic                 tx_irq,
    output logic                 modem_dtr
);

    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic                 wipe, scan_en, irq_en, dtr_n, load, ready;
    logic [NUM_LINES-1:0] line_en, line_busy;
    logic [LINE_W-1:0]    ready_line;
    logic [DATA_W-1:0]    load_data;

    stm_regs #(
        .NUM_LINES (NUM_LINES),
        .DATA_W    (DATA_W),
        .CLR_CYCLES(CLR_CYCLES),
        .LINE_W    (LINE_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ready     (ready),
        .ready_line(ready_line),
        .wipe      (wipe),
        .scan_en   (scan_en),
        .irq_en    (irq_en),
        .line_en   (line_en),
        .dtr_n     (dtr_n),
        .load      (load),
        .load_data (load_data)
    );

    stm_scanner #(
        .NUM_LINES(NUM_LINES),
        .LINE_W   (LINE_W)
    ) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .wipe     (wipe),
        .scan_en  (scan_en),
        .line_en  (line_en),
        .line_busy(line_busy),
        .load     (load),
        .ready    (ready),
        .line     (ready_line)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic line_load;
        assign line_load = load && (ready_line == LINE_W'(g));

        stm_shifter #(
            .DATA_W (DATA_W),
            .BIT_DIV(BIT_DIV)
        ) u_shift (
            .clk  (clk),
            .rst_n(rst_n),
            .wipe (wipe),
            .load (line_load),
            .data (load_data),
            .busy (line_busy[g]),
            .txd  (ser_out[g])
        );
    end

    assign tx_irq    = ready && irq_en;
    assign modem_dtr = !dtr_n;

    // R8: the interrupt needs a pending offer
    a_r8_irq_needs_offer: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> (ready && !wipe))
        else $error("interrupt without an offered line");

endmodule

// File: tb/serial_tx_mux_bench.sv
module serial_tx_mux_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NL  = 4;
    localparam int DW  = 8;
    localparam int BD  = 4;
    localparam int CLR = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [NL-1:0] ser_out;
    logic        tx_irq;
    logic        modem_dtr;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    serial_tx_mux #(
        .NUM_LINES (NL),
        .DATA_W    (DW),
        .BIT_DIV   (BD),
        .CLR_CYCLES(CLR)
    ) u_serial_tx_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .ser_out  (ser_out),
        .tx_irq   (tx_irq),
        .modem_dtr(modem_dtr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    function automatic int rr_first(input int from, input logic [NL-1:0] m);
        for (int i = 0; i < NL; i++) begin
            if (m[(from + i) % NL]) return (from + i) % NL;
        end
        return -1;
    endfunction

    task automatic wait_ready(output int line, output bit ok);
        logic [15:0] v;
        ok = 1'b0;
        line = -1;
        for (int i = 0; i < 40; i++) begin
            rd(2'd0, v);
            if (v[15]) begin
                line = int'(v[9:8]);
                ok = 1'b1;
                return;
            end
        end
    endtask

    task automatic send_frame(input int line, input logic [7:0] d);
        logic [9:0]    fr;
        logic [NL-1:0] expv;
        int cur;
        fr = {1'b1, d, 1'b0};
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = {8'h00, d};
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_addr = 2'd0;
        #1;
        check("R5 ready flag drops after data write", bus_rdata[15], 1'b0);
        cur = 1;
        for (int k = 0; k < 10; k++) begin
            while (cur < k*BD + BD/2) begin
                @(negedge clk);
                cur++;
            end
            #1;
            expv = '1;
            expv[line] = fr[k];
            check("R9 frame bit", ser_out, expv);
        end
        while (cur < 10*BD + 2) begin
            @(negedge clk);
            cur++;
        end
        #1;
        check("R9 idle mark after frame", ser_out, {NL{1'b1}});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int line, exp_ptr, p, want;
        bit ok;
        logic [NL-1:0] nm;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); check("R1 control reads zero", v, 16'h0000);
        rd(2'd1, v); check("R1 transmit control reset", v, 16'h8000);
        rd(2'd2, v); check("R1 data port reads zero", v, 16'h0000);
        rd(2'd3, v); check("R1 spare address reads zero", v, 16'h0000);
        check("R1 lines mark", ser_out, {NL{1'b1}});
        check("R1 no interrupt", tx_irq, 1'b0);
        check("R1 terminal-ready off", modem_dtr, 1'b0);

        // exhaustive enable-mask sweep
        exp_ptr = 0;
        for (int m = 1; m < 16; m++) begin
            wr(2'd0, 16'h0004);
            wr(2'd1, 16'h8000 | 16'(m));
            rd(2'd1, v); check("R2 enable readback", v, 16'h8000 | 16'(m));
            wr(2'd0, 16'h0006);
            wait_ready(line, ok);
            check("R3 a line gets offered", ok, 1'b1);
            check("R4 round-robin offered line", line, rr_first(exp_ptr, 4'(m)));
            check("R8 interrupt with offer", tx_irq, 1'b1);
            exp_ptr = line;
            send_frame(line, 8'((m * 37 + 11) & 8'hFF));
            exp_ptr = rr_first((line + 1) % NL, 4'(m));
        end

        // R8 interrupt gating
        wr(2'd0, 16'h0002);
        #1 check("R8 no interrupt when disabled", tx_irq, 1'b0);
        rd(2'd0, v);
        check("R3 flag still set", v[15], 1'b1);
        check("R4 pointer after last frame", int'(v[9:8]), exp_ptr);
        wr(2'd0, 16'h0006);
        #1 check("R8 interrupt when enabled", tx_irq, 1'b1);

        // R6 release the offered line and its neighbour
        p = exp_ptr;
        nm = 4'hF & ~(4'b1 << p) & ~(4'b1 << ((p + 1) % NL));
        wr(2'd1, 16'h8000 | 16'(nm));
        @(negedge clk);
        wait_ready(line, ok);
        check("R6 scan moves on", ok, 1'b1);
        check("R6 next enabled line offered", line, (p + 2) % NL);
        exp_ptr = line;

        // R7 scan disabled
        wr(2'd1, 16'h800F);
        wr(2'd0, 16'h0004);
        for (int i = 0; i < 6; i++) begin
            rd(2'd0, v);
            check("R7 flag low while scan off", v[15], 1'b0);
            check("R7 no interrupt while scan off", tx_irq, 1'b0);
        end

        // R5 data write with no offer is ignored
        wr(2'd2, 16'h00A5);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check("R5 ignored write leaves lines marking", ser_out, {NL{1'b1}});
        end

        // R11 modem terminal-ready
        wr(2'd1, 16'h000F);
        #1 check("R11 active-low bit asserts output", modem_dtr, 1'b1);
        wr(2'd1, 16'h800F);
        #1 check("R11 bit high releases output", modem_dtr, 1'b0);

        // R4 pointer preserved across scan off
        wr(2'd0, 16'h0002);
        wait_ready(line, ok);
        check("R4 pointer kept while scan off", line, exp_ptr);

        // R10 clear in the middle of a frame
        wr(2'd2, 16'h0000);
        wr(2'd0, 16'h0001);
        for (int k = 2; k <= CLR + 1; k++) begin
            rd(2'd0, v);
            check("R10 clear bit readback", v[0], (k <= CLR) ? 1'b1 : 1'b0);
            if (k == 3) check("R10 shifters wiped", ser_out, {NL{1'b1}});
        end
        rd(2'd0, v); check("R10 control after clear", v, 16'h0000);
        rd(2'd1, v); check("R10 transmit control after clear", v, 16'h8000);

        // R10 writes during clear are ignored
        wr(2'd0, 16'h0001);
        wr(2'd1, 16'h0005);
        repeat (CLR + 2) @(negedge clk);
        rd(2'd1, v); check("R10 write during clear ignored", v, 16'h8000);

        // R4 clear returns the pointer to line 0
        wr(2'd1, 16'h800F);
        wr(2'd0, 16'h0002);
        wait_ready(line, ok);
        check("R4 pointer at line 0 after clear", line, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule